// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches translations from 32-bit virtual addresses to physical addresses, with 4 KiB pages. It is fully associative. Each entry holds a virtual page number, an address-space identifier, a frame number and four flag bits: valid, present, writable and dirty. A lookup compares the requested page number and the current identifier against every entry in parallel within one cycle. The outcome is registered, so it appears on the response outputs one cycle after the request is accepted. A hit returns the stored frame number joined to the unchanged 12-bit page offset. A miss, or an access the mapping does not permit, raises a fault so that the requester can fetch the mapping, install it and retry.

Mappings are installed through a refill port. A refill whose page number and identifier match a valid entry rewrites that entry in place. Any other refill allocates the slot named by a round-robin pointer. Two maintenance inputs remove mappings: one invalidates every entry, and the other invalidates only the entries that carry a given identifier.

The control is a two-state machine. ST_IDLE is the state in which requests can be taken. ST_RESP is the state in which the registered result is shown. The ACCEPT transition moves from ST_IDLE to ST_RESP when a request handshake completes. The RETURN transition moves from ST_RESP back to ST_IDLE unconditionally one cycle later.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, rsp_valid is 0, and req_ready is 1 whenever no maintenance input is asserted.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. rsp_valid is then 1 for exactly the following cycle. req_ready is 0 during that cycle, and also in any cycle where fill_en, flush_all or flush_asid_en is 1.
- R3: A hit sets rsp_hit to 1 and rsp_paddr to {stored frame number, req_vaddr[11:0]}. The offset bits pass through unchanged.
- R4: A request with no valid entry of equal page number and identifier gives rsp_miss_fault=1, rsp_hit=0 and rsp_paddr=0. A matching entry whose present bit is 0 gives the same result. Exactly one of rsp_hit, rsp_miss_fault and rsp_prot_fault is 1 in every response.
- R5: An entry matches only when its identifier equals req_asid. The same page number may be mapped under two identifiers to different frames.
- R6: A write (req_write=1) that matches a present entry whose writable bit is 0 gives rsp_prot_fault=1, rsp_hit=0 and rsp_paddr=0. A read of the same entry hits.
- R7: A write hit sets the entry's dirty bit. rsp_dirty reports the entry's dirty bit after the access on a hit, and is 0 otherwise.
- R8: Refills that match no valid entry go to slots 0, 1, 2 and so on in order, wrapping after ENTRIES. The (ENTRIES+1)-th distinct refill after reset therefore evicts the first.
- R9: A refill with the page number and identifier of a valid entry overwrites that entry and does not advance the round-robin pointer. No two valid entries ever match one lookup.
- R10: flush_all invalidates every entry at the next clock edge.
- R11: flush_asid_en invalidates only the entries whose identifier equals flush_asid. Entries with other identifiers are unaffected.
- R12: In a cycle where flush_all or flush_asid_en is 1, fill_en is ignored. flush_all takes priority over flush_asid_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access |
| req_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Registered lookup result valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address on hit, 0 otherwise |
| rsp_dirty | output | 1 | Dirty bit of the hit entry after the access |
| rsp_miss_fault | output | 1 | No usable mapping |
| rsp_prot_fault | output | 1 | Write to a read-only mapping |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Page number of the mapping |
| fill_asid | input | 8 | Identifier of the mapping |
| fill_pfn | input | 20 | Frame number of the mapping |
| fill_present | input | 1 | Present flag |
| fill_writable | input | 1 | Writable flag |
| fill_dirty | input | 1 | Initial dirty flag |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | 8 | Identifier to invalidate |

## Verification
The bench maps one page number under two identifiers. A design that ignored the identifier would return the wrong frame for one of them. It refills ENTRIES+1 distinct pages and checks that only the oldest is evicted. A pointer that wrapped wrongly, or that advanced on an in-place refill, would drop a live mapping or create a duplicate match. Other scenarios check that a write to a read-only page faults without an address, that a write hit turns the dirty bit on, that non-present entries miss, that the identifier-selective flush keeps other identifiers, and that a flush beats a refill in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } tlb_state_e;

    typedef struct packed {
        logic hit;
        logic miss;
        logic prot;
        logic dirty;
    } tlb_result_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic [N-1:0]             tag_valid,
    input  logic [N-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [N-1:0][ASID_W-1:0] tag_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [N-1:0]             match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = tag_valid[g]
                        && (tag_vpn[g] == key_vpn)
                        && (tag_asid[g] == key_asid);
    end
endmodule

// File: rtl/tlb_onehot_enc.sv
module tlb_onehot_enc #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] onehot,
    output logic [W-1:0] index
);
    always_comb begin
        index = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) index = index | W'(i);
        end
    end
endmodule

// File: rtl/tlb_rr_victim.sv
module tlb_rr_victim #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == W'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic                    req_write,
    input  logic [ASID_W-1:0]       req_asid,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic                    rsp_dirty,
    output logic                    rsp_miss_fault,
    output logic                    rsp_prot_fault,
    input  logic                    fill_en,
    input  logic [VA_W-OFF_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic [PA_W-OFF_W-1:0]   fill_pfn,
    input  logic                    fill_present,
    input  logic                    fill_writable,
    input  logic                    fill_dirty,
    input  logic                    flush_all,
    input  logic                    flush_asid_en,
    input  logic [ASID_W-1:0]       flush_asid
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Entry storage
    logic [ENTRIES-1:0]             e_valid;
    logic [ENTRIES-1:0]             e_present;
    logic [ENTRIES-1:0]             e_writable;
    logic [ENTRIES-1:0]             e_dirty;
    logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
    logic [ENTRIES-1:0][PFN_W-1:0]  e_pfn;

    tlb_state_e  state_q, state_d;
    tlb_result_t look_res, res_q;
    logic [PFN_W-1:0] pfn_q;
    logic [OFF_W-1:0] off_q;

    logic maint, flushing, accept;
    logic [ENTRIES-1:0] look_match, fill_match;
    logic [IDX_W-1:0]   look_idx, fill_match_idx, victim_idx, fill_idx;
    logic look_any, fill_hit, victim_adv;
    logic sel_present, sel_writable, sel_dirty;

    assign flushing = flush_all || flush_asid_en;
    assign maint    = flushing || fill_en;
    assign accept   = req_valid && req_ready;

    // Lookup comparator bank
    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_look_cmp (
        .tag_valid (e_valid),
        .tag_vpn   (e_vpn),
        .tag_asid  (e_asid),
        .key_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .key_asid  (req_asid),
        .match     (look_match)
    );

    tlb_onehot_enc #(.N(ENTRIES), .W(IDX_W)) u_look_enc (
        .onehot (look_match),
        .index  (look_idx)
    );

    // Refill comparator bank (in-place update detection)
    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cmp (
        .tag_valid (e_valid),
        .tag_vpn   (e_vpn),
        .tag_asid  (e_asid),
        .key_vpn   (fill_vpn),
        .key_asid  (fill_asid),
        .match     (fill_match)
    );

    tlb_onehot_enc #(.N(ENTRIES), .W(IDX_W)) u_fill_enc (
        .onehot (fill_match),
        .index  (fill_match_idx)
    );

    assign fill_hit   = |fill_match;
    assign victim_adv = fill_en && !flushing && !fill_hit;
    assign fill_idx   = fill_hit ? fill_match_idx : victim_idx;

    tlb_rr_victim #(.N(ENTRIES), .W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (victim_adv),
        .ptr     (victim_idx)
    );

    // Lookup decision
    assign look_any     = |look_match;
    assign sel_present  = e_present[look_idx];
    assign sel_writable = e_writable[look_idx];
    assign sel_dirty    = e_dirty[look_idx];

    always_comb begin
        look_res.miss  = !look_any || !sel_present;
        look_res.prot  = look_any && sel_present && req_write && !sel_writable;
        look_res.hit   = look_any && sel_present && !(req_write && !sel_writable);
        look_res.dirty = look_res.hit && (sel_dirty || req_write);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;   // ACCEPT
            ST_RESP: state_d = ST_IDLE;               // RETURN
            default: state_d = ST_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = !maint;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // Registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            pfn_q <= '0;
            off_q <= '0;
        end else if (accept) begin
            res_q <= look_res;
            pfn_q <= look_res.hit ? e_pfn[look_idx] : '0;
            off_q <= look_res.hit ? req_vaddr[OFF_W-1:0] : '0;
        end
    end

    assign rsp_hit        = rsp_valid && res_q.hit;
    assign rsp_miss_fault = rsp_valid && res_q.miss;
    assign rsp_prot_fault = rsp_valid && res_q.prot;
    assign rsp_dirty      = rsp_valid && res_q.dirty;
    assign rsp_paddr      = rsp_valid ? {pfn_q, off_q} : '0;

    // Entry updates: flush > flush by identifier > refill > dirty marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid    <= '0;
            e_present  <= '0;
            e_writable <= '0;
            e_dirty    <= '0;
            e_vpn      <= '0;
            e_asid     <= '0;
            e_pfn      <= '0;
        end else if (flush_all) begin
            e_valid <= '0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (e_asid[i] == flush_asid) e_valid[i] <= 1'b0;
            end
        end else if (fill_en) begin
            e_valid[fill_idx]    <= 1'b1;
            e_present[fill_idx]  <= fill_present;
            e_writable[fill_idx] <= fill_writable;
            e_dirty[fill_idx]    <= fill_dirty;
            e_vpn[fill_idx]      <= fill_vpn;
            e_asid[fill_idx]     <= fill_asid;
            e_pfn[fill_idx]      <= fill_pfn;
        end else if (accept && look_res.hit && req_write) begin
            e_dirty[look_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               rsp_miss_fault,
    input logic               rsp_prot_fault,
    input logic               fill_en,
    input logic               flush_all,
    input logic               flush_asid_en,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] look_match
);
    p_accept_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_single_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_maint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en || flush_all || flush_asid_en) |-> !req_ready);

    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss_fault, rsp_prot_fault}) == 1));

    p_prot_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_prot_fault) |-> (rsp_paddr == '0));

    p_fill_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_asid_en) |=> (valid_vec != '0));

    p_unique_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_match));

    p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));
endmodule

bind asid_tlb asid_tlb_checker #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .OFF_W   (OFF_W)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_paddr      (rsp_paddr),
    .rsp_miss_fault (rsp_miss_fault),
    .rsp_prot_fault (rsp_prot_fault),
    .fill_en        (fill_en),
    .flush_all      (flush_all),
    .flush_asid_en  (flush_asid_en),
    .valid_vec      (e_valid),
    .look_match     (look_match)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_vaddr;
    logic [7:0]  req_asid;
    logic        rsp_valid, rsp_hit, rsp_dirty, rsp_miss_fault, rsp_prot_fault;
    logic [31:0] rsp_paddr;
    logic        fill_en, fill_present, fill_writable, fill_dirty;
    logic [19:0] fill_vpn, fill_pfn;
    logic [7:0]  fill_asid;
    logic        flush_all, flush_asid_en;
    logic [7:0]  flush_asid;

    int checks = 0;
    int fails  = 0;

    logic        o_hit, o_miss, o_prot, o_dirty, o_ready;
    logic [31:0] o_paddr;

    always #10 clk = ~clk;

    asid_tlb uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_asid(req_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_dirty(rsp_dirty), .rsp_miss_fault(rsp_miss_fault),
        .rsp_prot_fault(rsp_prot_fault),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_present(fill_present),
        .fill_writable(fill_writable), .fill_dirty(fill_dirty),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en),
        .flush_asid(flush_asid)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0; req_asid = '0;
        fill_en = 1'b0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0;
        fill_present = 1'b1; fill_writable = 1'b1; fill_dirty = 1'b0;
        flush_all = 1'b0; flush_asid_en = 1'b0; flush_asid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn,
                        input logic p, input logic w, input logic d);
        fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        fill_present = p; fill_writable = w; fill_dirty = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Request at a negedge; result sampled at the next negedge; idle again one cycle later.
    task automatic lookup(input logic [31:0] va, input logic wr, input logic [7:0] asid);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_asid = asid;
        @(negedge clk);
        req_valid = 1'b0;
        o_hit = rsp_hit; o_miss = rsp_miss_fault; o_prot = rsp_prot_fault;
        o_dirty = rsp_dirty; o_paddr = rsp_paddr; o_ready = req_ready;
        check("R2 rsp_valid one cycle after accept", 64'(rsp_valid), 64'd1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);
        lookup(32'h0000_0123, 1'b0, 8'd0);
        check("R1/R4 empty table misses", 64'(o_miss), 64'd1);
        check("R4 miss paddr zero", 64'(o_paddr), 64'd0);
        check("R2 single-cycle response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_hit();
        do_reset();
        fill_en = 1'b1;
        #1 check("R2 req_ready low during refill", 64'(req_ready), 64'd0);
        fill_en = 1'b0;
        fill(20'h12345, 8'd3, 20'hABCDE, 1'b1, 1'b1, 1'b0);
        lookup(32'h1234_5678, 1'b0, 8'd3);
        check("R3 hit", 64'(o_hit), 64'd1);
        check("R3 paddr", 64'(o_paddr), 64'hABCD_E678);
        check("R2 req_ready low in response cycle", 64'(o_ready), 64'd0);
        lookup(32'h1234_5FFF, 1'b0, 8'd3);
        check("R3 paddr top offset", 64'(o_paddr), 64'hABCD_EFFF);
        lookup(32'h1234_6000, 1'b0, 8'd3);
        check("R4 neighbour page misses", 64'(o_miss), 64'd1);
    endtask

    task automatic t_asid();
        do_reset();
        fill(20'h00400, 8'd1, 20'h11111, 1'b1, 1'b1, 1'b0);
        lookup(32'h0040_0010, 1'b0, 8'd2);
        check("R5 other identifier misses", 64'(o_miss), 64'd1);
        fill(20'h00400, 8'd2, 20'h22222, 1'b1, 1'b1, 1'b0);
        lookup(32'h0040_0010, 1'b0, 8'd1);
        check("R5 identifier 1 frame", 64'(o_paddr), 64'h1111_1010);
        lookup(32'h0040_0010, 1'b0, 8'd2);
        check("R5 identifier 2 frame", 64'(o_paddr), 64'h2222_2010);
    endtask

    task automatic t_present();
        do_reset();
        fill(20'h00777, 8'd0, 20'h33333, 1'b0, 1'b1, 1'b0);
        lookup(32'h0077_7004, 1'b0, 8'd0);
        check("R4 non-present entry misses", 64'(o_miss), 64'd1);
        check("R4 non-present not hit", 64'(o_hit), 64'd0);
    endtask

    task automatic t_prot();
        do_reset();
        fill(20'h00AAA, 8'd5, 20'h44444, 1'b1, 1'b0, 1'b0);
        lookup(32'h00AA_A100, 1'b1, 8'd5);
        check("R6 write to read-only faults", 64'(o_prot), 64'd1);
        check("R6 no hit on protection fault", 64'(o_hit), 64'd0);
        check("R6 no paddr on protection fault", 64'(o_paddr), 64'd0);
        lookup(32'h00AA_A100, 1'b0, 8'd5);
        check("R6 read of read-only hits", 64'(o_paddr), 64'h4444_4100);
    endtask

    task automatic t_dirty();
        do_reset();
        fill(20'h00BBB, 8'd6, 20'h55555, 1'b1, 1'b1, 1'b0);
        lookup(32'h00BB_B000, 1'b0, 8'd6);
        check("R7 clean on read", 64'(o_dirty), 64'd0);
        lookup(32'h00BB_B000, 1'b1, 8'd6);
        check("R7 write hit", 64'(o_hit), 64'd1);
        check("R7 dirty after write", 64'(o_dirty), 64'd1);
        lookup(32'h00BB_B000, 1'b0, 8'd6);
        check("R7 dirty stays set", 64'(o_dirty), 64'd1);
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int i = 0; i < 17; i++) fill(20'(i + 16), 8'd9, 20'(i + 32'h100), 1'b1, 1'b1, 1'b0);
        lookup({20'd16, 12'h0}, 1'b0, 8'd9);
        check("R8 oldest evicted", 64'(o_miss), 64'd1);
        lookup({20'd17, 12'h0}, 1'b0, 8'd9);
        check("R8 second kept", 64'(o_paddr), 64'h0010_1000);
        lookup({20'd32, 12'h0}, 1'b0, 8'd9);
        check("R8 newest in slot 0", 64'(o_paddr), 64'h0011_0000);
    endtask

    task automatic t_inplace();
        do_reset();
        fill(20'h0CCCC, 8'd7, 20'h00001, 1'b1, 1'b1, 1'b0);
        fill(20'h0CCCC, 8'd7, 20'h00002, 1'b1, 1'b1, 1'b0);
        lookup(32'h0CCC_C008, 1'b0, 8'd7);
        check("R9 refill overwrites", 64'(o_paddr), 64'h0000_2008);
        for (int i = 0; i < 15; i++) fill(20'(i + 1), 8'd7, 20'(i + 32'h200), 1'b1, 1'b1, 1'b0);
        lookup(32'h0CCC_C008, 1'b0, 8'd7);
        check("R9 pointer not advanced by in-place refill", 64'(o_paddr), 64'h0000_2008);
    endtask

    task automatic t_flush_all();
        do_reset();
        fill(20'h00010, 8'd1, 20'h00020, 1'b1, 1'b1, 1'b0);
        fill(20'h00011, 8'd2, 20'h00021, 1'b1, 1'b1, 1'b0);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        lookup(32'h0001_0000, 1'b0, 8'd1);
        check("R10 flush removes identifier 1", 64'(o_miss), 64'd1);
        lookup(32'h0001_1000, 1'b0, 8'd2);
        check("R10 flush removes identifier 2", 64'(o_miss), 64'd1);
    endtask

    task automatic t_flush_asid();
        do_reset();
        fill(20'h00010, 8'd1, 20'h00020, 1'b1, 1'b1, 1'b0);
        fill(20'h00011, 8'd2, 20'h00021, 1'b1, 1'b1, 1'b0);
        flush_asid_en = 1'b1; flush_asid = 8'd1;
        @(negedge clk);
        flush_asid_en = 1'b0;
        lookup(32'h0001_0000, 1'b0, 8'd1);
        check("R11 selected identifier removed", 64'(o_miss), 64'd1);
        lookup(32'h0001_1abc, 1'b0, 8'd2);
        check("R11 other identifier kept", 64'(o_paddr), 64'h0002_1abc);
    endtask

    task automatic t_flush_prio();
        do_reset();
        flush_all = 1'b1;
        fill(20'h00042, 8'd3, 20'h00043, 1'b1, 1'b1, 1'b0);
        flush_all = 1'b0;
        lookup(32'h0004_2000, 1'b0, 8'd3);
        check("R12 refill ignored during flush", 64'(o_miss), 64'd1);
        flush_asid_en = 1'b1; flush_asid = 8'd99;
        fill(20'h00042, 8'd3, 20'h00043, 1'b1, 1'b1, 1'b0);
        flush_asid_en = 1'b0;
        lookup(32'h0004_2000, 1'b0, 8'd3);
        check("R12 refill ignored during identifier flush", 64'(o_miss), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_hit();
        t_asid();
        t_present();
        t_prot();
        t_dirty();
        t_round_robin();
        t_inplace();
        t_flush_all();
        t_flush_asid();
        t_flush_prio();
        summary();
        $finish;
    end
endmodule